// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Splitter

This block sits at the front of a simple one-instruction-per-cycle processor. It takes the current program counter and a window of instruction-memory bytes beginning at that address. From these it produces the fields of one instruction: operation code, function code, the two register specifiers and the 64-bit constant. It also produces the address of the next sequential instruction and a flag for an unknown operation code. Instructions are 1, 2, 9 or 10 bytes long. The length is fixed by the operation code, and any constant sits unaligned and least-significant-byte-first inside the byte stream.

Field splitting and length computation are purely combinational. A program-counter register is built in alongside them. It resets to a parameterised address, loads an external address on request, or advances to the computed next address. A parameter chooses whether decoding works from this register or directly from the external PC input. This lets the same block be exercised either as a free-standing decoder or as a self-stepping fetch unit.

Top module: `fetch_splitter`

## Requirements
- R1: `icode` equals bits [7:4] of window byte 0 and `ifun` equals bits [3:0] of window byte 0, for every operation code including unknown ones. Window byte i occupies bits [8i+7:8i] of `win` and is the byte at address PC+i.
- R2: `valp` equals PC plus the instruction length, wrapping modulo 2^64. The length is 1 byte for codes 0x0, 0x1 and 0x9, 2 bytes for codes 0x2, 0x6, 0xA and 0xB, 9 bytes for codes 0x7 and 0x8, and 10 bytes for codes 0x3, 0x4 and 0x5.
- R3: For an operation code above 0xB, `invalid` is 1, `valp` equals PC+1, `ra` and `rb` are 0xF and `valc` is 0. For every other code `invalid` is 0.
- R4: For codes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB, `ra` equals bits [7:4] of window byte 1 and `rb` equals bits [3:0] of window byte 1. For all other codes both are 0xF, the "no register" value.
- R5: For codes 0x3, 0x4 and 0x5, `valc` is window bytes 2 to 9 with byte 2 least significant. For codes 0x7 and 0x8, it is bytes 1 to 8 with byte 1 least significant. For every other code `valc` is 0, and window bytes past the instruction's length have no effect on any output.
- R6: While `rst_n` is low at a rising clock edge, `pc_reg` is set to RESET_PC.
- R7: When `pc_load` is 1 at a rising edge out of reset, `pc_reg` takes `pc_in`, whatever the value of `step`.
- R8: When `step` is 1 and `pc_load` is 0 at a rising edge, `pc_reg` takes `valp`. When both are 0, `pc_reg` keeps its value.
- R9: With REG_PC = 1 the decode PC (`pc_cur`, from which `valp` is formed) is `pc_reg`, and `pc_in` then affects nothing but loads. With REG_PC = 0 the decode PC is `pc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the PC register |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_load | input | 1 | Load `pc_in` into the PC register |
| step | input | 1 | Advance the PC register to `valp` |
| pc_in | input | 64 | External PC: load value, or decode PC when REG_PC = 0 |
| win | input | 80 | Ten instruction bytes starting at the decode PC, byte 0 lowest |
| pc_reg | output | 64 | Current PC register value |
| pc_cur | output | 64 | PC the present decode refers to |
| icode | output | 4 | Operation code |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register specifier, 0xF if absent |
| rb | output | 4 | Second register specifier, 0xF if absent |
| valc | output | 64 | Instruction constant, 0 if absent |
| valp | output | 64 | Address of the next sequential instruction |
| invalid | output | 1 | Operation code is not defined |

## Verification
The bench builds two copies side by side. One has REG_PC = 0, so a table of hand-encoded instructions can put any PC straight at the decoder. This reaches every operation code, constants at both byte offsets, garbage past the instruction end, and PC wrap-around at the top of the address space. The other has REG_PC = 1 and RESET_PC = 0x100. It makes the register's reset, load priority, hold and self-stepping over instructions of different lengths observable, while `pc_in` carries junk that must not leak into `valp`.

// File: rtl/fetch_pkg.sv
// Shared definitions for the fetch splitter.
// Assumes 4-bit operation codes and a register specifier nibble where 0xF means "none".
package fetch_pkg;

    localparam logic [3:0] NO_REG = 4'hF;

    localparam logic [3:0] OPC_HALT  = 4'h0;
    localparam logic [3:0] OPC_NOP   = 4'h1;
    localparam logic [3:0] OPC_CMOV  = 4'h2;
    localparam logic [3:0] OPC_LDIMM = 4'h3;
    localparam logic [3:0] OPC_STORE = 4'h4;
    localparam logic [3:0] OPC_LOAD  = 4'h5;
    localparam logic [3:0] OPC_ALU   = 4'h6;
    localparam logic [3:0] OPC_JUMP  = 4'h7;
    localparam logic [3:0] OPC_CALL  = 4'h8;
    localparam logic [3:0] OPC_RET   = 4'h9;
    localparam logic [3:0] OPC_PUSH  = 4'hA;
    localparam logic [3:0] OPC_POP   = 4'hB;

    // Instruction layout summary produced by the format decoder.
    typedef struct packed {
        logic       valid;    // operation code is defined
        logic       has_reg;  // byte 1 carries two register specifiers
        logic       has_imm;  // a constant is present
        logic       imm_at1;  // constant starts at byte 1 (else byte 2)
        logic [3:0] len;      // length in bytes
    } fmt_t;

endpackage

// File: rtl/fetch_format_decode.sv
// Maps an operation code to its instruction layout.
// Assumes codes above 0xB are undefined; those get a 1-byte length and no fields.
module fetch_format_decode
    import fetch_pkg::*;
(
    input  logic [3:0] icode,
    output fmt_t       fmt
);

    // Purpose: table from operation code to length and field presence.
    always_comb begin
        fmt = '{valid: 1'b0, has_reg: 1'b0, has_imm: 1'b0, imm_at1: 1'b0, len: 4'd1};
        case (icode)
            OPC_HALT, OPC_NOP, OPC_RET: begin
                fmt.valid = 1'b1;
                fmt.len   = 4'd1;
            end
            OPC_CMOV, OPC_ALU, OPC_PUSH, OPC_POP: begin
                fmt.valid   = 1'b1;
                fmt.has_reg = 1'b1;
                fmt.len     = 4'd2;
            end
            OPC_JUMP, OPC_CALL: begin
                fmt.valid   = 1'b1;
                fmt.has_imm = 1'b1;
                fmt.imm_at1 = 1'b1;
                fmt.len     = 4'd9;
            end
            OPC_LDIMM, OPC_STORE, OPC_LOAD: begin
                fmt.valid   = 1'b1;
                fmt.has_reg = 1'b1;
                fmt.has_imm = 1'b1;
                fmt.len     = 4'd10;
            end
            default: begin
                fmt.valid = 1'b0;
                fmt.len   = 4'd1;
            end
        endcase
    end

endmodule

// File: rtl/fetch_field_extract.sv
// Pulls register specifiers and the little-endian constant out of the bytes
// that follow byte 0. Assumes win_tail byte k is instruction byte k+1.
module fetch_field_extract
    import fetch_pkg::*;
#(
    parameter int IMM_BYTES = 8,
    localparam int TAIL_W   = 8 * (IMM_BYTES + 1),
    localparam int IMM_W    = 8 * IMM_BYTES
) (
    input  logic [TAIL_W-1:0] win_tail,
    input  fmt_t              fmt,
    output logic [3:0]        ra,
    output logic [3:0]        rb,
    output logic [IMM_W-1:0]  valc
);

    logic [7:0] reg_byte;
    assign reg_byte = win_tail[7:0];

    // Purpose: present register specifiers or the "none" value.
    always_comb begin
        if (fmt.has_reg) begin
            ra = reg_byte[7:4];
            rb = reg_byte[3:0];
        end else begin
            ra = NO_REG;
            rb = NO_REG;
        end
    end

    // One byte lane per constant byte, choosing between the two possible offsets.
    for (genvar b = 0; b < IMM_BYTES; b++) begin : g_imm_lane
        logic [7:0] from_b1;
        logic [7:0] from_b2;
        assign from_b1 = win_tail[8*b +: 8];
        assign from_b2 = win_tail[8*(b+1) +: 8];

        // Purpose: select the lane's byte, or zero when no constant exists.
        always_comb begin
            if (!fmt.has_imm)
                valc[8*b +: 8] = 8'h00;
            else if (fmt.imm_at1)
                valc[8*b +: 8] = from_b1;
            else
                valc[8*b +: 8] = from_b2;
        end
    end

endmodule

// File: rtl/fetch_pc_unit.sv
// Program-counter register plus next-address adder.
// Assumes a synchronous active-low reset; REG_PC picks the decode PC source.
module fetch_pc_unit #(
    parameter int              PC_W     = 64,
    parameter bit              REG_PC   = 1'b1,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_load,
    input  logic            step,
    input  logic [PC_W-1:0] pc_in,
    input  logic [3:0]      len,
    output logic [PC_W-1:0] pc_reg,
    output logic [PC_W-1:0] pc_cur,
    output logic [PC_W-1:0] valp
);

    // Purpose: PC register with reset, load and step, load taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_reg <= RESET_PC;
        else if (pc_load)
            pc_reg <= pc_in;
        else if (step)
            pc_reg <= valp;
    end

    if (REG_PC) begin : g_from_reg
        assign pc_cur = pc_reg;
    end else begin : g_from_port
        assign pc_cur = pc_in;
    end

    // Purpose: next sequential address, wrapping at the top of the space.
    always_comb begin
        valp = pc_cur + {{(PC_W-4){1'b0}}, len};
    end

endmodule

// File: rtl/fetch_splitter.sv
// Top of the fetch splitter: splits one instruction from a byte window and
// forms the next address. Assumes the window starts at pc_cur, byte 0 lowest.
module fetch_splitter
    import fetch_pkg::*;
#(
    parameter int                  PC_W      = 64,
    parameter int                  IMM_BYTES = 8,
    parameter bit                  REG_PC    = 1'b1,
    parameter logic [PC_W-1:0]     RESET_PC  = '0,
    localparam int                 WIN_W     = 8 * (IMM_BYTES + 2),
    localparam int                 IMM_W     = 8 * IMM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_load,
    input  logic              step,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [WIN_W-1:0]  win,
    output logic [PC_W-1:0]   pc_reg,
    output logic [PC_W-1:0]   pc_cur,
    output logic [3:0]        icode,
    output logic [3:0]        ifun,
    output logic [3:0]        ra,
    output logic [3:0]        rb,
    output logic [IMM_W-1:0]  valc,
    output logic              invalid,
    output logic [PC_W-1:0]   valp
);

    fmt_t fmt;

    assign icode   = win[7:4];
    assign ifun    = win[3:0];
    assign invalid = !fmt.valid;

    fetch_format_decode u_fmt (
        .icode (icode),
        .fmt   (fmt)
    );

    fetch_field_extract #(.IMM_BYTES(IMM_BYTES)) u_fields (
        .win_tail (win[WIN_W-1:8]),
        .fmt      (fmt),
        .ra       (ra),
        .rb       (rb),
        .valc     (valc)
    );

    fetch_pc_unit #(.PC_W(PC_W), .REG_PC(REG_PC), .RESET_PC(RESET_PC)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pc_load (pc_load),
        .step    (step),
        .pc_in   (pc_in),
        .len     (fmt.len),
        .pc_reg  (pc_reg),
        .pc_cur  (pc_cur),
        .valp    (valp)
    );

endmodule

// File: rtl/fetch_splitter_chk.sv
// Property checker for fetch_splitter, attached by bind.
module fetch_splitter_chk #(
    parameter int PC_W  = 64,
    parameter int IMM_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pc_load,
    input logic             step,
    input logic [PC_W-1:0]  pc_in,
    input logic [PC_W-1:0]  pc_reg,
    input logic [PC_W-1:0]  pc_cur,
    input logic [3:0]       icode,
    input logic [3:0]       ra,
    input logic [3:0]       rb,
    input logic [IMM_W-1:0] valc,
    input logic             invalid,
    input logic [PC_W-1:0]  valp
);

    a_r3_invalid_next: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (valp == pc_cur + PC_W'(1) && ra == 4'hF && rb == 4'hF && valc == '0));

    a_r3_flag_range: assert property (@(posedge clk) disable iff (!rst_n)
        invalid == (icode > 4'hB));

    a_r2_long_len: assert property (@(posedge clk) disable iff (!rst_n)
        (icode == 4'h3 || icode == 4'h4 || icode == 4'h5) |-> valp == pc_cur + PC_W'(10));

    a_r2_branch_len: assert property (@(posedge clk) disable iff (!rst_n)
        (icode == 4'h7 || icode == 4'h8) |-> valp == pc_cur + PC_W'(9));

    a_r4_no_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (icode == 4'h0 || icode == 4'h1 || icode == 4'h7 || icode == 4'h8 || icode == 4'h9)
        |-> (ra == 4'hF && rb == 4'hF));

    a_r5_no_imm: assert property (@(posedge clk) disable iff (!rst_n)
        (icode <= 4'h2 || icode == 4'h6 || icode >= 4'h9) |-> valc == '0);

    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> pc_reg == $past(pc_in));

    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !pc_load) |=> pc_reg == $past(valp));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !pc_load) |=> $stable(pc_reg));

endmodule

bind fetch_splitter fetch_splitter_chk #(.PC_W(PC_W), .IMM_W(IMM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pc_load (pc_load),
    .step    (step),
    .pc_in   (pc_in),
    .pc_reg  (pc_reg),
    .pc_cur  (pc_cur),
    .icode   (icode),
    .ra      (ra),
    .rb      (rb),
    .valc    (valc),
    .invalid (invalid),
    .valp    (valp)
);

// File: tb/fetch_splitter_tb_top.sv
module fetch_splitter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    typedef struct packed {
        logic [63:0] pc;
        logic [79:0] win;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [63:0] valc;
        logic [63:0] valp;
        logic        inv;
    } vec_t;

    // Hand-encoded instructions; window byte 0 is the rightmost byte.
    localparam vec_t VECS [0:NV-1] = '{
        '{64'h0,    80'hffffffffffffffffff00, 4'hf, 4'hf, 64'h0, 64'h1,   1'b0},
        '{64'h100,  80'h99887766554433221210, 4'hf, 4'hf, 64'h0, 64'h101, 1'b0},
        '{64'h200,  80'haaaaaaaaaaaaaaaa0321, 4'h0, 4'h3, 64'h0, 64'h202, 1'b0},
        '{64'h0,    80'h0000000000000001f230, 4'hf, 4'h2, 64'h1, 64'ha,   1'b0},
        '{64'h1000, 80'h08070605040302011340, 4'h1, 4'h3, 64'h0807060504030201, 64'h100a, 1'b0},
        '{64'ha,    80'h00000000000000000250, 4'h0, 4'h2, 64'h0, 64'h14,  1'b0},
        '{64'h14,   80'hffffffffffffffff2360, 4'h2, 4'h3, 64'h0, 64'h16,  1'b0},
        '{64'h16,   80'hee000000000000012374, 4'hf, 4'hf, 64'h123, 64'h1f, 1'b0},
        '{64'h40,   80'hcc112233445566778880, 4'hf, 4'hf, 64'h1122334455667788, 64'h49, 1'b0},
        '{64'h49,   80'h55555555555555555590, 4'hf, 4'hf, 64'h0, 64'h4a,  1'b0},
        '{64'h50,   80'h00000000000000000fa0, 4'h0, 4'hf, 64'h0, 64'h52,  1'b0},
        '{64'h52,   80'h00000000000000007fb0, 4'h7, 4'hf, 64'h0, 64'h54,  1'b0},
        '{64'h60,   80'h121212121212121212c0, 4'hf, 4'hf, 64'h0, 64'h61,  1'b1},
        '{64'hffffffffffffffff, 80'h000000000000000000f5, 4'hf, 4'hf, 64'h0, 64'h0, 1'b1},
        '{64'hfffffffffffffffa, 80'h7ffffffffffffffff730, 4'hf, 4'h7, 64'h7fffffffffffffff, 64'h4, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pc_load;
    logic        step;
    logic [63:0] pc_in;
    logic [79:0] win;

    logic [63:0] c_pc_reg, c_pc_cur, c_valc, c_valp;
    logic [3:0]  c_icode, c_ifun, c_ra, c_rb;
    logic        c_inv;
    logic [63:0] r_pc_reg, r_pc_cur, r_valc, r_valp;
    logic [3:0]  r_icode, r_ifun, r_ra, r_rb;
    logic        r_inv;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_splitter #(.REG_PC(1'b0), .RESET_PC(64'h0)) dut_i (
        .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .step(step), .pc_in(pc_in), .win(win),
        .pc_reg(c_pc_reg), .pc_cur(c_pc_cur), .icode(c_icode), .ifun(c_ifun), .ra(c_ra),
        .rb(c_rb), .valc(c_valc), .invalid(c_inv), .valp(c_valp)
    );

    fetch_splitter #(.REG_PC(1'b1), .RESET_PC(64'h100)) dut_reg_i (
        .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .step(step), .pc_in(pc_in), .win(win),
        .pc_reg(r_pc_reg), .pc_cur(r_pc_cur), .icode(r_icode), .ifun(r_ifun), .ra(r_ra),
        .rb(r_rb), .valc(r_valc), .invalid(r_inv), .valp(r_valp)
    );

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pc_load = 1'b0; step = 1'b0;
        pc_in = 64'h0; win = 80'h10;
        tick(); tick(); tick();
        // R6: reset value of the register copy
        check("R6", "pc_reg after reset", r_pc_reg, 64'h100);
        check("R9", "reg decode pc", r_pc_cur, 64'h100);
        rst_n = 1'b1;
        tick();

        // Table walk on the port-driven copy: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            pc_in = VECS[i].pc;
            win   = VECS[i].win;
            #1;
            check("R1", $sformatf("icode v%0d", i), {60'h0, c_icode}, {60'h0, VECS[i].win[7:4]});
            check("R1", $sformatf("ifun v%0d", i), {60'h0, c_ifun}, {60'h0, VECS[i].win[3:0]});
            check("R4", $sformatf("ra v%0d", i), {60'h0, c_ra}, {60'h0, VECS[i].ra});
            check("R4", $sformatf("rb v%0d", i), {60'h0, c_rb}, {60'h0, VECS[i].rb});
            check("R5", $sformatf("valc v%0d", i), c_valc, VECS[i].valc);
            check("R2", $sformatf("valp v%0d", i), c_valp, VECS[i].valp);
            check("R3", $sformatf("invalid v%0d", i), {63'h0, c_inv}, {63'h0, VECS[i].inv});
            check("R9", $sformatf("port decode pc v%0d", i), c_pc_cur, VECS[i].pc);
        end
        tick();

        // R8: register held through the table walk with step low
        check("R8", "hold with step low", r_pc_reg, 64'h100);

        // R9: junk on pc_in must not reach valp of the register copy
        pc_in = 64'hdead_beef_0000_0000;
        win = VECS[1].win;
        step = 1'b1;
        #1;
        check("R9", "valp ignores pc_in", r_valp, 64'h101);
        tick();
        check("R8", "step over 1-byte", r_pc_reg, 64'h101);
        win = VECS[3].win;
        #1;
        check("R2", "reg valp 10-byte", r_valp, 64'h10b);
        tick();
        check("R8", "step over 10-byte", r_pc_reg, 64'h10b);
        step = 1'b0;
        tick(); tick();
        check("R8", "hold two cycles", r_pc_reg, 64'h10b);

        // R7: load wins over step
        pc_load = 1'b1; step = 1'b1; pc_in = 64'h500;
        tick();
        check("R7", "load priority", r_pc_reg, 64'h500);
        pc_load = 1'b0;
        win = VECS[12].win;
        tick();
        check("R3", "step over invalid", r_pc_reg, 64'h501);
        win = VECS[8].win;
        #1;
        check("R5", "call constant via reg copy", r_valc, 64'h1122334455667788);
        tick();
        check("R2", "step over call", r_pc_reg, 64'h50a);

        // R6: synchronous reset mid-run
        step = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R6", "no change before edge", r_pc_reg, 64'h50a);
        tick();
        check("R6", "reset mid-run", r_pc_reg, 64'h100);
        rst_n = 1'b1;
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule